// File: doc/BRIEF.md
# SPI Data Chunk Transmit Scheduler

This block sits on the host side of a serial link to an Ethernet MAC-PHY. It takes outgoing frames as a byte stream and cuts them into fixed chunks for an SPI shifter. Each chunk is one 32-bit header word followed by a 64-byte payload. The block holds one payload in a local buffer, fills unused payload bytes with zeros, and writes the header so that the far end knows whether the payload carries frame data, whether a frame starts in it, and where the frame ends.

Two counters control when chunks go out. The first counts the transmit credits the device has granted. The second counts the receive chunks the device is waiting to return. Both counters are loaded from a status-register value at start-up. After that, every footer word that comes back from the device replaces them. A data chunk is sent only while a credit remains. When no data chunk can be sent but the device still holds receive chunks, the block sends empty chunks so that those receive chunks are clocked out. A transmit-error flag in a footer stops all new chunks until software clears it.

Both streams use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. Once the block raises `out_valid`, it holds `out_word` and `out_last` steady until `out_ready` is seen. `in_ready` drops while a chunk is being sent and while the buffer holds a finished payload, so a stalled output pushes back on the frame source.

Top module: `spi_chunk_tx`

## Requirements
- R1: A chunk is 17 words on `out_word`. The first word is the header. `out_last` is high only on the 17th word. Payload byte n of a word sits in bits [31-8n:24-8n], so the first byte of the stream is the most significant byte.
- R2: Header bit layout: bit 31 is a constant 1 (data, not control). Bit 21 means the payload holds frame data. Bit 20 means a frame starts in the payload, and bits 19:16 give the start word offset. Bit 14 means the frame ends in the payload, and bits 13:8 give the end byte offset. Bit 0 is set so that the header has an odd number of ones. All other bits are 0.
- R3: Every frame starts at payload byte 0 of a new chunk, with bit 20 set and bits 19:16 equal to 0. Chunks in the middle of a frame have neither bit 20 nor bit 14 set. The last chunk of a frame has bit 14 set and an end offset of (length-1) mod 64. Payload bytes after the end of the frame are 0.
- R4: A data chunk starts only while the credit count is nonzero. Starting a data chunk lowers the credit count by one.
- R5: A `stat_load` pulse sets both counts from `stat_credits` and `stat_rxpend`. A valid footer replaces both counts. When both arrive in the same cycle, `stat_load` wins. A footer or load overrides any decrement in the same cycle.
- R6: Each chunk that starts, data or empty, lowers the receive-pending count by one, stopping at 0. When no data chunk can start and the receive-pending count is nonzero, an empty chunk is sent: header 32'h8000_0000 and an all-zero payload. With both counts at zero and no issuable data, no chunk is sent.
- R7: Footer layout: bit 31 is the transmit-error flag, bits 12:8 are the receive-chunks-available count, and bits 4:0 are the credit count.
- R8: A footer with the error flag set raises `err_o`. While `err_o` is high, no new chunk starts. `err_clr` lowers `err_o`. If an error footer and `err_clr` arrive in the same cycle, the error wins.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word` and `out_last` stay unchanged on the next cycle.
- R10: `in_ready` is low while a chunk is being sent and while the buffer holds a finished payload that is waiting to be sent.
- R11: After reset, both counts are 0, `err_o` is 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block can accept a frame byte |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first byte of a frame |
| in_eof | input | 1 | Byte is the last byte of a frame |
| stat_load | input | 1 | Load both counts from the status value |
| stat_credits | input | 5 | Initial transmit credit count |
| stat_rxpend | input | 5 | Initial receive-pending count |
| ftr_valid | input | 1 | Footer word valid |
| ftr_word | input | 32 | Footer returned by the device |
| err_clr | input | 1 | Clear the transmit error |
| out_valid | output | 1 | Chunk word valid |
| out_ready | input | 1 | Shifter accepts the chunk word |
| out_word | output | 32 | Header or payload word |
| out_last | output | 1 | Last word of the chunk |
| tx_credits | output | 5 | Current credit count |
| rx_pend | output | 5 | Current receive-pending count |
| err_o | output | 1 | Transmit error latched |

## Verification
If the credit counter is wrong, a data chunk goes out while `tx_credits` reads 0, or a queued frame stalls while credits remain. Either shows within one or two cycles of the count update. If the buffer fill count is off, the end offset in the header is wrong, or payload bytes move or lose their zero padding. This shows in the header word and the 16 words after it. If the chunk-word sequencer is off, `out_last` lands on the wrong word, or a stalled word changes under back-pressure, on the very next edge. If the error latch is wrong, chunks keep starting after an error footer, or never resume after `err_clr`.

// File: rtl/sct_pkg.sv
package sct_pkg;
  // header bit positions (decoded by the device)
  localparam int HDR_DNC     = 31;
  localparam int HDR_DV      = 21;
  localparam int HDR_SV      = 20;
  localparam int HDR_SWO_LSB = 16;
  localparam int HDR_EV      = 14;
  localparam int HDR_EBO_LSB = 8;
  localparam int HDR_PAR     = 0;
  localparam int EBO_W       = 6;

  // footer bit positions (driven by the device)
  localparam int FTR_TXERR   = 31;
  localparam int FTR_RXP_LSB = 8;
  localparam int FTR_CRD_LSB = 0;

  typedef struct packed {
    logic             dv;
    logic             sv;
    logic             ev;
    logic [EBO_W-1:0] ebo;
  } chunk_meta_t;
endpackage

// File: rtl/sct_hdr.sv
module sct_hdr
  import sct_pkg::*;
(
  input  chunk_meta_t meta,
  output logic [31:0] hdr
);
  logic [31:0] body;

  always_comb begin
    body                         = '0;
    body[HDR_DNC]                = 1'b1;
    body[HDR_DV]                 = meta.dv;
    body[HDR_SV]                 = meta.sv;
    body[HDR_SWO_LSB +: 4]       = 4'd0;
    body[HDR_EV]                 = meta.ev;
    body[HDR_EBO_LSB +: EBO_W]   = meta.ebo;
    hdr                          = body;
    hdr[HDR_PAR]                 = ~(^body);
  end
endmodule

// File: rtl/sct_fill.sv
module sct_fill
  import sct_pkg::*;
#(
  parameter int BYTES = 64,
  localparam int PW = $clog2(BYTES / 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          hold,
  output logic          in_ready,
  input  logic          release_buf,
  output logic          ready_o,
  output chunk_meta_t   meta,
  input  logic [PW-1:0] rd_idx,
  output logic [31:0]   rd_word
);
  localparam int CW = $clog2(BYTES + 1);
  localparam int AW = $clog2(BYTES);

  logic [7:0]    mem [BYTES];
  logic [CW-1:0] cnt;
  logic          sv_q, ev_q, full_q;
  logic          acc;
  logic [CW-1:0] last_idx;

  assign in_ready = !full_q && !hold;
  assign acc      = in_valid && in_ready;
  assign ready_o  = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sv_q   <= 1'b0;
      ev_q   <= 1'b0;
      full_q <= 1'b0;
    end else if (release_buf) begin
      cnt    <= '0;
      sv_q   <= 1'b0;
      ev_q   <= 1'b0;
      full_q <= 1'b0;
    end else if (acc) begin
      cnt    <= cnt + CW'(1);
      if (in_sof) sv_q <= 1'b1;
      if (in_eof) ev_q <= 1'b1;
      full_q <= in_eof || (cnt == CW'(BYTES - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (acc) mem[cnt[AW-1:0]] <= in_data;
  end

  always_comb begin
    last_idx  = cnt - CW'(1);
    meta.dv   = 1'b1;
    meta.sv   = sv_q;
    meta.ev   = ev_q;
    meta.ebo  = ev_q ? last_idx[EBO_W-1:0] : '0;
  end

  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [AW-1:0] ra;
    logic          in_rng;
    always_comb begin
      ra     = AW'(int'(rd_idx) * 4 + b);
      in_rng = (int'(rd_idx) * 4 + b) < int'(cnt);
    end
    assign rd_word[31-8*b -: 8] = in_rng ? mem[ra] : 8'h00;
  end
endmodule

// File: rtl/sct_credit.sv
module sct_credit
  import sct_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_load,
  input  logic [CNT_W-1:0] stat_credits,
  input  logic [CNT_W-1:0] stat_rxpend,
  input  logic             ftr_valid,
  input  logic [31:0]      ftr_word,
  input  logic             err_clr,
  input  logic             take_data,
  input  logic             take_any,
  output logic [CNT_W-1:0] credits,
  output logic [CNT_W-1:0] rxpend,
  output logic             err
);
  logic ftr_unused;
  assign ftr_unused = ^ftr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credits <= '0;
      rxpend  <= '0;
    end else if (stat_load) begin
      credits <= stat_credits;
      rxpend  <= stat_rxpend;
    end else if (ftr_valid) begin
      credits <= ftr_word[FTR_CRD_LSB +: CNT_W];
      rxpend  <= ftr_word[FTR_RXP_LSB +: CNT_W];
    end else begin
      if (take_data && credits != '0) credits <= credits - CNT_W'(1);
      if (take_any && rxpend != '0)   rxpend  <= rxpend - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             err <= 1'b0;
    else if (ftr_valid && ftr_word[FTR_TXERR]) err <= 1'b1;
    else if (err_clr)                       err <= 1'b0;
  end
endmodule

// File: rtl/spi_chunk_tx.sv
module spi_chunk_tx
  import sct_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64,
  parameter int CNT_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             stat_load,
  input  logic [CNT_W-1:0] stat_credits,
  input  logic [CNT_W-1:0] stat_rxpend,
  input  logic             ftr_valid,
  input  logic [31:0]      ftr_word,
  input  logic             err_clr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_word,
  output logic             out_last,
  output logic [CNT_W-1:0] tx_credits,
  output logic [CNT_W-1:0] rx_pend,
  output logic             err_o
);
  localparam int PAY_WORDS   = PAYLOAD_BYTES / 4;
  localparam int CHUNK_WORDS = PAY_WORDS + 1;
  localparam int WIDX_W      = $clog2(CHUNK_WORDS);
  localparam int PIDX_W      = $clog2(PAY_WORDS);

  typedef enum logic {S_IDLE, S_SEND} st_e;

  st_e               state;
  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] pidx;
  logic              is_data;
  logic              fill_ready, start_data, start_empty, release_buf;
  logic              at_last, last_beat;
  chunk_meta_t       fill_meta, meta_sel;
  logic [31:0]       hdr_word, pay_word;

  assign start_data  = (state == S_IDLE) && !err_o && fill_ready && (tx_credits != '0);
  assign start_empty = (state == S_IDLE) && !err_o && !start_data && (rx_pend != '0);
  assign at_last     = (widx == WIDX_W'(CHUNK_WORDS - 1));
  assign last_beat   = (state == S_SEND) && out_ready && at_last;
  assign release_buf = last_beat && is_data;
  assign pidx        = widx - WIDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      widx    <= '0;
      is_data <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_data || start_empty) begin
            state   <= S_SEND;
            widx    <= '0;
            is_data <= start_data;
          end
        end
        default: begin
          if (out_ready) begin
            if (at_last) state <= S_IDLE;
            else         widx  <= widx + WIDX_W'(1);
          end
        end
      endcase
    end
  end

  sct_fill #(.BYTES(PAYLOAD_BYTES)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .hold       (state != S_IDLE),
    .in_ready   (in_ready),
    .release_buf(release_buf),
    .ready_o    (fill_ready),
    .meta       (fill_meta),
    .rd_idx     (pidx[PIDX_W-1:0]),
    .rd_word    (pay_word)
  );

  sct_credit #(.CNT_W(CNT_W)) u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat_load   (stat_load),
    .stat_credits(stat_credits),
    .stat_rxpend (stat_rxpend),
    .ftr_valid   (ftr_valid),
    .ftr_word    (ftr_word),
    .err_clr     (err_clr),
    .take_data   (start_data),
    .take_any    (start_data || start_empty),
    .credits     (tx_credits),
    .rxpend      (rx_pend),
    .err         (err_o)
  );

  assign meta_sel = is_data ? fill_meta : '0;

  sct_hdr u_hdr (
    .meta(meta_sel),
    .hdr (hdr_word)
  );

  assign out_valid = (state == S_SEND);
  assign out_last  = out_valid && at_last;
  assign out_word  = !out_valid    ? '0 :
                     (widx == '0)  ? hdr_word :
                     is_data       ? pay_word : '0;
endmodule

// File: rtl/sct_chk.sv
module sct_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_word,
  input logic             out_last,
  input logic             in_ready,
  input logic             err_o,
  input logic             err_clr,
  input logic             stat_load,
  input logic             ftr_valid,
  input logic [CNT_W-1:0] tx_credits
);
  // R1
  chunk_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_word[31] && !out_last));

  // R4
  credit_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && out_word[21] && !$past(stat_load) && !$past(ftr_valid))
      |-> ($past(tx_credits) != '0 && tx_credits == $past(tx_credits) - CNT_W'(1)));

  // R8
  no_start_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(err_o));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !err_clr) |=> err_o);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

  // R10
  input_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

bind spi_chunk_tx sct_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_last  (out_last),
  .in_ready  (in_ready),
  .err_o     (err_o),
  .err_clr   (err_clr),
  .stat_load (stat_load),
  .ftr_valid (ftr_valid),
  .tx_credits(tx_credits)
);

// File: tb/spi_chunk_tx_tb.sv
module spi_chunk_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam int V_LEN  [NV] = '{1, 60, 64, 65, 130};
  localparam int V_NCH  [NV] = '{1, 1, 1, 2, 3};
  localparam int V_SEED [NV] = '{8'h11, 8'h3c, 8'h70, 8'h05, 8'hc2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        stat_load = 1'b0;
  logic [4:0]  stat_credits = '0, stat_rxpend = '0;
  logic        ftr_valid = 1'b0;
  logic [31:0] ftr_word = '0;
  logic        err_clr = 1'b0;
  logic        out_valid, out_last;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic [4:0]  tx_credits, rx_pend;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] cap_w [17];
  logic        cap_l [17];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_chunk_tx u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .stat_load(stat_load), .stat_credits(stat_credits), .stat_rxpend(stat_rxpend),
    .ftr_valid(ftr_valid), .ftr_word(ftr_word), .err_clr(err_clr),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_last(out_last),
    .tx_credits(tx_credits), .rx_pend(rx_pend), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int seed, input int i);
    return 8'(seed + i * 5 + (i >> 3));
  endfunction

  function automatic logic [31:0] exp_hdr(input bit dv, input bit sv, input bit ev, input int ebo);
    logic [31:0] h;
    h = '0;
    h[31] = 1'b1;
    h[21] = dv;
    h[20] = sv;
    h[14] = ev;
    h[13:8] = 6'(ebo);
    h[0] = ~(^h);
    return h;
  endfunction

  task automatic load_stat(input int c, input int r);
    stat_credits = 5'(c); stat_rxpend = 5'(r); stat_load = 1'b1;
    @(negedge clk);
    stat_load = 1'b0;
  endtask

  task automatic send_ftr(input logic [31:0] w);
    ftr_word = w; ftr_valid = 1'b1;
    @(negedge clk);
    ftr_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit s, input bit e);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int i = 0; i < len; i++) send_byte(fb(seed, i), i == 0, i == len - 1);
  endtask

  task automatic get_chunk();
    #1;
    for (int w = 0; w < 17; w++) begin
      while (!(out_valid && out_ready)) begin @(negedge clk); #1; end
      cap_w[w] = out_word;
      cap_l[w] = out_last;
      @(negedge clk); #1;
    end
  endtask

  // checks header, payload and framing of one chunk (R1, R2, R3, R6)
  task automatic check_chunk(input int len, input int k, input int seed, input bit empty, input string req);
    logic [31:0] eh, ew;
    int n, idx, badl;
    bit last;
    get_chunk();
    n = (len + 63) / 64;
    last = (k == n - 1);
    if (empty) eh = exp_hdr(0, 0, 0, 0);
    else       eh = exp_hdr(1, k == 0, last, last ? (len - 1) % 64 : 0);
    chk(cap_w[0] == eh, {req, " header"}, cap_w[0], eh);
    for (int w = 1; w < 17; w++) begin
      for (int b = 0; b < 4; b++) begin
        idx = k * 64 + (w - 1) * 4 + b;
        ew[31-8*b -: 8] = (!empty && idx < len) ? fb(seed, idx) : 8'h00;
      end
      chk(cap_w[w] == ew, {req, " payload"}, cap_w[w], ew);
    end
    badl = 0;
    for (int w = 0; w < 17; w++) if (cap_l[w] != (w == 16)) badl++;
    chk(badl == 0, "R1 last-word marker", 32'(badl), 32'd0);
  endtask

  task automatic idle_check(input int cyc, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); #1; if (out_valid) bad++; end
    chk(bad == 0, req, 32'(bad), 32'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w0;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R11 in_ready", 32'(in_ready), 32'd1);
    chk(err_o == 1'b0, "R11 err_o", 32'(err_o), 32'd0);
    chk(tx_credits == 5'd0 && rx_pend == 5'd0, "R11 counts",
        {tx_credits, 3'b0, rx_pend}, 32'd0);
    @(negedge clk);

    // table of frames: R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      load_stat(20, 0);
      fork
        send_frame(V_LEN[v], V_SEED[v]);
        for (int k = 0; k < V_NCH[v]; k++) check_chunk(V_LEN[v], k, V_SEED[v], 0, "R3 frame");
      join
      @(negedge clk); #1;
      chk(tx_credits == 5'(20 - V_NCH[v]), "R4 credit use", 32'(tx_credits), 32'(20 - V_NCH[v]));
      @(negedge clk);
    end

    // R4 credit gating, R5 footer refresh
    load_stat(1, 0);
    fork
      send_frame(130, 8'h9a);
      begin
        check_chunk(130, 0, 8'h9a, 0, "R4 first");
        idle_check(30, "R4 no credit stall");
        chk(tx_credits == 5'd0, "R4 credits empty", 32'(tx_credits), 32'd0);
        send_ftr(32'h0000_0002);
        check_chunk(130, 1, 8'h9a, 0, "R5 after footer");
        check_chunk(130, 2, 8'h9a, 0, "R5 after footer");
      end
    join
    @(negedge clk); #1;
    chk(tx_credits == 5'd0, "R4 credits after", 32'(tx_credits), 32'd0);

    // R6 empty chunks drain receive data
    @(negedge clk);
    load_stat(0, 3);
    for (int k = 0; k < 3; k++) check_chunk(0, 0, 0, 1, "R6 empty");
    idle_check(20, "R6 stop at zero");
    chk(rx_pend == 5'd0, "R6 rx_pend zero", 32'(rx_pend), 32'd0);

    // R10 full buffer blocks input; R6 empty chunks while data lacks credit
    @(negedge clk);
    send_frame(10, 8'h44);
    #1;
    chk(in_ready == 1'b0, "R10 buffer full", 32'(in_ready), 32'd0);
    idle_check(10, "R4 held without credit");
    @(negedge clk);
    load_stat(0, 2);
    check_chunk(0, 0, 0, 1, "R6 empty before data");
    check_chunk(0, 0, 0, 1, "R6 empty before data");
    idle_check(5, "R6 nothing left");
    send_ftr(32'h0000_0001);
    check_chunk(10, 0, 8'h44, 0, "R3 short frame");

    // R5 priority and replacement
    @(negedge clk);
    stat_credits = 5'd7; stat_rxpend = 5'd0; stat_load = 1'b1;
    ftr_word = 32'h0000_0003; ftr_valid = 1'b1;
    @(negedge clk);
    stat_load = 1'b0; ftr_valid = 1'b0;
    #1;
    chk(tx_credits == 5'd7, "R5 load wins", 32'(tx_credits), 32'd7);
    @(negedge clk);
    send_ftr(32'h0000_0003);
    #1;
    chk(tx_credits == 5'd3, "R5 footer replaces", 32'(tx_credits), 32'd3);

    // R7 footer fields, R8 error stops issue
    @(negedge clk);
    send_ftr(32'h8000_0205);
    #1;
    chk(err_o == 1'b1, "R8 err raised", 32'(err_o), 32'd1);
    chk(tx_credits == 5'd5, "R7 credit field", 32'(tx_credits), 32'd5);
    chk(rx_pend == 5'd2, "R7 rxpend field", 32'(rx_pend), 32'd2);
    idle_check(20, "R8 blocked by error");
    chk(err_o == 1'b1, "R8 err sticky", 32'(err_o), 32'd1);
    @(negedge clk);
    ftr_word = 32'h8000_0000; ftr_valid = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    ftr_valid = 1'b0; err_clr = 1'b0;
    #1;
    chk(err_o == 1'b1, "R8 set beats clear", 32'(err_o), 32'd1);
    @(negedge clk);
    load_stat(0, 2);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    #1;
    chk(err_o == 1'b0, "R8 err cleared", 32'(err_o), 32'd0);
    @(negedge clk);
    check_chunk(0, 0, 0, 1, "R8 resume");
    check_chunk(0, 0, 0, 1, "R8 resume");

    // R9 back-pressure hold, R10 input blocked while sending
    @(negedge clk);
    out_ready = 1'b0;
    load_stat(1, 0);
    send_frame(8, 8'h21);
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b1, "R9 valid under stall", 32'(out_valid), 32'd1);
    chk(in_ready == 1'b0, "R10 sending blocks input", 32'(in_ready), 32'd0);
    w0 = out_word;
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      if (!out_valid || out_word != w0) bad++;
    end
    chk(bad == 0, "R9 word held", 32'(bad), 32'd0);
    @(negedge clk);
    out_ready = 1'b1;
    check_chunk(8, 0, 8'h21, 0, "R9 after stall");

    @(negedge clk);
    finish_run();
  end
endmodule